// File: doc/BRIEF.md
# Paired-Update Eight-Channel DAC Register Block

This block sits on a narrow byte-wide register bus and feeds the digital codes of eight 12-bit DAC channels. Software builds a 12-bit code from two byte writes and stores it in the input latch of one channel, chosen through a select register. A later read at the low-byte offset moves latched codes into the output registers. Only the even/odd channel pair that contains the selected channel moves, or all eight move at once when the broadcast bit of the select register is set.

Each channel therefore has two stages: an input latch that software fills, and an output register that drives the DAC code port. This allows several channels to be prepared in advance and then switched together. A clear bit in the select register forces every output code to zero and leaves the input latches alone. An interrupt-request flag is set by an external pulse. It is visible in a status byte and is cleared as a side effect of reading the high-byte offset.

The interface is synchronous. Read and write strobes last one cycle. Reset is asynchronous, active low, and is released in step with the clock.

Top module: `pairdac_regs`

## Requirements
- R1: After reset, every channel code, every input latch, the select register, the clear bit and the interrupt flag are zero, and a select readback returns 0x00.
- R2: A write at offset 0 stages the low 8 code bits. A following write at offset 1 supplies code bits 11:8 from its data bits 3:0, and data bits 7:4 of that byte are ignored.
- R3: A write at offset 1 while select bit 3 is 0 stores the assembled code only in the input latch of the channel indexed by select bits 2:0. Writes alone never change any channel output.
- R4: A read at offset 0 while select bit 3 is 0 copies the input latches of channels 2k and 2k+1 into their outputs, where k is select bits 2:1. The partner channel shows whatever its own latch holds, and the other pairs keep their outputs.
- R5: While select bit 3 is 1, a read at offset 0 copies all eight input latches into the outputs at once, and a write at offset 1 stores nothing in any latch.
- R6: A read at offset 2 returns the select register, meaning bits 3:0 as written and the clear bit at bit 4, with bits 7:5 zero. Read data appears on the cycle after the read strobe.
- R7: A pulse on the interrupt-set input raises the interrupt flag. The flag is reported at bit 3 of a read at offset 4 and is cleared by a read at offset 1. If a set pulse and that read occur in the same cycle, the flag stays set.
- R8: Writing select bit 4 as 1 forces all channel codes to zero right after that write, and offset-0 reads do not lift them. After bit 4 is written back to 0, the outputs stay zero until the next offset-0 read restores the latched codes of the channels it moves.
- R9: A read at offset 0 returns 0x00 on the read data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| irq_set | input | 1 | Pulse that raises the interrupt flag |
| irq_flag | output | 1 | Interrupt-request flag |
| dac_code | output | 96 | Channel codes, channel n at bits 12n+11:12n |

## Verification
Latch writes, select writes and the clear gating take effect at the clock edge that samples the write strobe. Output transfers appear at the edge that samples an offset-0 read, and read data appears one register stage after the read strobe. The bench drives every strobe on a falling edge and drops it at the next falling edge. It then compares codes, flag and read data at that second falling edge, half a period after the edge that updates them. A reference model in the bench, written from the requirements, tracks latch and output contents so that each partner channel and each untouched pair is compared after every transfer.

// File: rtl/pairdac_pkg.sv
package pairdac_pkg;
  localparam int BUS_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int IRQ_BIT = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_LSB  = 3'd0,
    OFS_MSB  = 3'd1,
    OFS_SEL  = 3'd2,
    OFS_STAT = 3'd4
  } ofs_e;
endpackage

// File: rtl/pairdac_channel.sv
module pairdac_channel #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_code,
  input  logic              xfer_en,
  input  logic              clr,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] latch_q, latch_d;
  logic [CODE_W-1:0] out_q, out_d;

  always_comb begin
    latch_d = latch_q;
    out_d   = out_q;
    if (load_en) latch_d = load_code;
    if (clr)          out_d = '0;
    else if (xfer_en) out_d = latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      out_q   <= '0;
    end else begin
      latch_q <= latch_d;
      out_q   <= out_d;
    end
  end

  assign code = clr ? '0 : out_q;
endmodule

// File: rtl/pairdac_ctrl.sv
module pairdac_ctrl
  import pairdac_pkg::*;
#(
  parameter int CH_COUNT = 8,
  parameter int CODE_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic                irq_set,
  output logic [CH_COUNT-1:0] load_mask,
  output logic [CODE_W-1:0]   load_code,
  output logic [CH_COUNT-1:0] xfer_mask,
  output logic                clr,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic                irq_flag
);
  localparam int SEL_W = $clog2(CH_COUNT);
  localparam int HI_W  = CODE_W - BUS_W;

  logic [BUS_W-1:0] lsb_q, lsb_d;
  logic [SEL_W:0]   sel_q, sel_d;
  logic             clr_q, clr_d;
  logic             irq_q, irq_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;

  logic wr_lsb, wr_msb, wr_sel, rd_lsb, rd_msb;
  logic all_mode;
  logic [SEL_W-1:0] chan_idx;
  logic [SEL_W-2:0] pair_idx;

  assign wr_lsb = bus_wr && (bus_addr == OFS_LSB);
  assign wr_msb = bus_wr && (bus_addr == OFS_MSB);
  assign wr_sel = bus_wr && (bus_addr == OFS_SEL);
  assign rd_lsb = bus_rd && (bus_addr == OFS_LSB);
  assign rd_msb = bus_rd && (bus_addr == OFS_MSB);

  assign all_mode = sel_q[SEL_W];
  assign chan_idx = sel_q[SEL_W-1:0];
  assign pair_idx = sel_q[SEL_W-1:1];

  always_comb begin
    lsb_d   = lsb_q;
    sel_d   = sel_q;
    clr_d   = clr_q;
    irq_d   = irq_q;
    rdata_d = rdata_q;
    if (wr_lsb) lsb_d = bus_wdata;
    if (wr_sel) begin
      sel_d = bus_wdata[SEL_W:0];
      clr_d = bus_wdata[SEL_W+1];
    end
    if (rd_msb)  irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
    if (bus_rd) begin
      rdata_d = '0;
      case (bus_addr)
        OFS_SEL:  rdata_d[SEL_W+1:0] = {clr_q, sel_q};
        OFS_STAT: rdata_d[IRQ_BIT]   = irq_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q   <= '0;
      sel_q   <= '0;
      clr_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      lsb_q   <= lsb_d;
      sel_q   <= sel_d;
      clr_q   <= clr_d;
      irq_q   <= irq_d;
      rdata_q <= rdata_d;
    end
  end

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_mask
    assign load_mask[i] = wr_msb && !all_mode && (chan_idx == SEL_W'(i));
    assign xfer_mask[i] = rd_lsb && (all_mode || (pair_idx == (SEL_W-1)'(i / 2)));
  end

  assign load_code = {bus_wdata[HI_W-1:0], lsb_q};
  assign clr       = clr_q;
  assign bus_rdata = rdata_q;
  assign irq_flag  = irq_q;
endmodule

// File: rtl/pairdac_regs.sv
module pairdac_regs
  import pairdac_pkg::*;
#(
  parameter int CH_COUNT = 8,
  parameter int CODE_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [2:0]                 bus_addr,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic                       irq_set,
  output logic                       irq_flag,
  output logic [CH_COUNT*CODE_W-1:0] dac_code
);
  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic [CH_COUNT-1:0] load_mask, xfer_mask;
  logic [CODE_W-1:0]   load_code;
  logic                clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pairdac_ctrl #(.CH_COUNT(CH_COUNT), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq_set(irq_set),
    .load_mask(load_mask), .load_code(load_code), .xfer_mask(xfer_mask),
    .clr(clr), .bus_rdata(bus_rdata), .irq_flag(irq_flag)
  );

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
    pairdac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .load_en(load_mask[i]), .load_code(load_code),
      .xfer_en(xfer_mask[i]), .clr(clr),
      .code(dac_code[i*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/pairdac_regs_chk.sv
module pairdac_regs_chk #(
  parameter int CH_COUNT = 8,
  parameter int CODE_W   = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [2:0]                 bus_addr,
  input logic [7:0]                 bus_wdata,
  input logic [7:0]                 bus_rdata,
  input logic                       irq_set,
  input logic                       irq_flag,
  input logic [CH_COUNT*CODE_W-1:0] dac_code
);
  // R3: without an update read or a select write the codes hold
  a_r3_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_rd && bus_addr == 3'd0) && !(bus_wr && bus_addr == 3'd2)) |=> $stable(dac_code));

  // R8: clear bit written as one zeroes every code
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && bus_wdata[4]) |=> (dac_code == '0));

  // R7: set pulse raises the flag
  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_flag);

  // R7: offset-1 read without a set pulse drops the flag
  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd1 && !irq_set) |=> !irq_flag);

  // R7: flag holds otherwise
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_set && !(bus_rd && bus_addr == 3'd1)) |=> $stable(irq_flag));

  // R9: offset-0 read returns zero
  a_r9_lsb_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0) |=> (bus_rdata == 8'h00));
endmodule

bind pairdac_regs pairdac_regs_chk #(.CH_COUNT(CH_COUNT), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_set(irq_set), .irq_flag(irq_flag), .dac_code(dac_code)
);

// File: tb/pairdac_regs_test.sv
`timescale 1ns/1ps
module pairdac_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, irq_set = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_flag;
  logic [95:0] dac_code;

  int n_checks = 0, n_fail = 0;
  logic [11:0] latch_m [8];
  logic [11:0] out_m [8];
  logic [7:0]  lsb_m;
  logic [3:0]  sel_m;
  logic        clr_m;

  always #2.5 clk = ~clk;

  pairdac_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_set(irq_set), .irq_flag(irq_flag), .dac_code(dac_code)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic check_codes(input string req);
    for (int c = 0; c < 8; c++)
      chk(req, 32'(dac_code[c*12 +: 12]), clr_m ? 32'h0 : 32'(out_m[c]));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    case (a)
      3'd0: lsb_m = d;
      3'd1: if (!sel_m[3]) latch_m[sel_m[2:0]] = {d[3:0], lsb_m};
      3'd2: begin
        sel_m = d[3:0]; clr_m = d[4];
        if (clr_m) for (int c = 0; c < 8; c++) out_m[c] = '0;
      end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    d = bus_rdata;
    if (a == 3'd0 && !clr_m)
      for (int c = 0; c < 8; c++)
        if (sel_m[3] || (c / 2) == int'(sel_m[2:1])) out_m[c] = latch_m[c];
  endtask

  task automatic load(input int ch, input logic [11:0] code, input logic [3:0] junk);
    wr(3'd2, 8'(ch));
    wr(3'd0, code[7:0]);
    wr(3'd1, {junk, code[11:8]});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check_codes("R1");
    chk("R1", 32'(irq_flag), 0);
    rd(3'd2, d); chk("R1", 32'(d), 0);
  endtask

  task automatic t_pair_update();
    logic [7:0] d;
    load(3, 12'h5AB, 4'hF);            // R2 upper nibble ignored
    check_codes("R3");                 // R3 writes alone leave outputs
    rd(3'd0, d);
    check_codes("R2");
    chk("R2", 32'(dac_code[36 +: 12]), 32'h5AB);
    chk("R9", 32'(d), 0);
    load(6, 12'h123, 4'h0);
    load(7, 12'h456, 4'hA);
    rd(3'd0, d);
    check_codes("R4");
  endtask

  task automatic t_partner();
    logic [7:0] d;
    load(0, 12'h111, 4'h0);
    rd(3'd0, d);
    check_codes("R4");
    load(1, 12'h222, 4'h0);
    check_codes("R3");                 // only ch1 latch changed, nothing shown
    rd(3'd0, d);
    check_codes("R4");                 // partner ch0 keeps its latched code
    chk("R4", 32'(dac_code[0 +: 12]), 32'h111);
  endtask

  task automatic t_broadcast();
    logic [7:0] d;
    load(4, 12'hABC, 4'h0);
    wr(3'd2, 8'h08);
    wr(3'd0, 8'hFF); wr(3'd1, 8'h0F);  // R5 no latch written in broadcast
    check_codes("R5");
    rd(3'd0, d);
    check_codes("R5");
    chk("R5", 32'(dac_code[48 +: 12]), 32'hABC);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(3'd2, 8'h0D);
    rd(3'd2, d); chk("R6", 32'(d), 32'h0D);
    wr(3'd2, 8'hF5);
    rd(3'd2, d); chk("R6", 32'(d), 32'h15);
    wr(3'd2, 8'h02);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(3'd2, 8'h12);
    check_codes("R8");
    chk("R8", 32'(dac_code == '0), 1);
    rd(3'd0, d);
    check_codes("R8");
    wr(3'd2, 8'h02);
    check_codes("R8");                 // still zero after release
    chk("R8", 32'(dac_code == '0), 1);
    rd(3'd0, d);
    check_codes("R8");
    chk("R8", 32'(dac_code[36 +: 12]), 32'h5AB);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    chk("R7", 32'(irq_flag), 1);
    rd(3'd4, d); chk("R7", 32'(d), 32'h08);
    rd(3'd1, d); chk("R7", 32'(irq_flag), 0);
    rd(3'd4, d); chk("R7", 32'(d), 32'h00);
    @(negedge clk); irq_set = 1'b1; bus_rd = 1'b1; bus_addr = 3'd1;
    @(negedge clk); irq_set = 1'b0; bus_rd = 1'b0;
    chk("R7", 32'(irq_flag), 1);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin latch_m[c] = '0; out_m[c] = '0; end
    lsb_m = '0; sel_m = '0; clr_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pair_update();
    t_partner();
    t_broadcast();
    t_readback();
    t_clear();
    t_irq();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule